// File: doc/BRIEF.md
# Maskable BCD Alarm Comparator

This block compares the live calendar time against a programmed alarm word and raises a sticky alarm flag. The alarm word has four BCD fields: date, hour (with a PM bit), minute and second. Each field has its own don't-care bit. The timekeeper supplies the current BCD time and date and a one-cycle pulse at each 1 Hz tick. The comparison is evaluated only on that pulse, so a match that holds for a whole second raises the flag once. Month and year are never compared, which limits an alarm to at most one month ahead.

Software programs the block through a plain register write port. Address 0 is the alarm word. Address 1 holds the control bits: the match enable and the interrupt enable. Address 2 is a write-one-to-clear strobe for the flag. The interrupt output is the flag qualified by the interrupt enable. A second-resolution alarm is only honoured when the synchronous prescaler value supplied by the timekeeper is at least 3. There is no streaming data path, so every pin is a plain control or status pin.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset, alarm_flag and alarm_irq are 0, and both control bits read as cleared, so no tick sets the flag before the control register is written.
- R2: Alarm word layout: seconds in bits [6:0] (tens [6:4], units [3:0]); minutes in [14:8] (tens [14:12], units [11:8]); hours in [21:16] (tens [21:20], units [19:16]) with PM at bit 22; date in [29:24] (tens [29:28], units [27:24]). With every mask clear, a tick at which all four fields equal the live inputs sets alarm_flag on that clock edge.
- R3: Mask bits 7 (second), 15 (minute), 23 (hour) and 31 (date) each make their field match whatever the live value is. A mismatch in any unmasked field prevents the flag from setting.
- R4: The hour comparison includes the PM bit, so a difference only in PM is a mismatch unless the hour mask is set.
- R5: The flag sets only in a cycle where tick_1hz is 1. A matching time without a tick leaves the flag at 0.
- R6: Control bit 8 enables matching. With it at 0 a matching tick does not set the flag, and an already set flag stays set.
- R7: alarm_irq is 1 exactly when alarm_flag is 1 and control bit 12 is 1.
- R8: Writing address 2 with bit 0 at 1 clears the flag on that edge. Writing address 2 with bit 0 at 0 has no effect. If a setting match and a clear fall in the same cycle, the flag ends set.
- R9: When the second mask (bit 7) is 0 and sync_div is below 3, no tick sets the flag. With bit 7 at 1 the divider value does not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 alarm word, 1 control, 2 flag clear |
| reg_wdata | input | 32 | Write data |
| tick_1hz | input | 1 | One-cycle pulse per calendar second |
| sync_div | input | 15 | Synchronous prescaler value in use |
| now_sec | input | 7 | Live BCD seconds (tens [6:4], units [3:0]) |
| now_min | input | 7 | Live BCD minutes |
| now_hour | input | 6 | Live BCD hours (tens [5:4], units [3:0]) |
| now_pm | input | 1 | Live PM indicator |
| now_date | input | 6 | Live BCD day of month |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench builds the block with its default parameters: a 15-bit divider and a minimum divider value of 3 for second matching. This keeps the alarm word small enough to sweep all sixteen mask combinations against every choice of a single mismatching field, or none, including a PM-only difference. A second sweep steps sync_div across the threshold with the second field masked and unmasked. Directed sequences then cover ticks that are absent, a disabled match with a held flag, clears with bit 0 at 0 and at 1, and a clear that coincides with a match.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int unsigned NFIELD   = 4;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned DIV_W    = 15;
  // field order: second, minute, hour(+PM), date
  localparam int unsigned FLD_LSB  [NFIELD] = '{0, 8, 16, 24};
  localparam int unsigned FLD_W    [NFIELD] = '{7, 7, 7, 6};
  localparam int unsigned FLD_DC   [NFIELD] = '{7, 15, 23, 31};
  localparam int unsigned EN_BIT   = 8;
  localparam int unsigned IE_BIT   = 12;
  localparam int unsigned CLR_BIT  = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_WORD = 2'd0,
    A_CTRL = 2'd1,
    A_CLR  = 2'd2
  } alarm_addr_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] want,
  input  logic [W-1:0] have,
  input  logic         dont_care,
  output logic         hit
);
  always_comb hit = dont_care || (want == have);
endmodule

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] word_q,
  output logic              en_q,
  output logic              ie_q,
  output logic              clr_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_WORD) word_q <= reg_wdata;
      if (reg_addr == A_CTRL) begin
        en_q <= reg_wdata[EN_BIT];
        ie_q <= reg_wdata[IE_BIT];
      end
    end
  end

  always_comb clr_req = reg_wr && (reg_addr == A_CLR) && reg_wdata[CLR_BIT];
endmodule

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag_q
);
  // a match in the same cycle as a clear wins, so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
#(
  parameter int unsigned MIN_SEC_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              tick_1hz,
  input  logic [DIV_W-1:0]  sync_div,
  input  logic [6:0]        now_sec,
  input  logic [6:0]        now_min,
  input  logic [5:0]        now_hour,
  input  logic              now_pm,
  input  logic [5:0]        now_date,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  logic [WORD_W-1:0] alarm_word;
  logic              alarm_en;
  logic              irq_en;
  logic              clr_req;
  logic [WORD_W-1:0] live_word;
  logic [NFIELD-1:0] fld_hit;
  logic              div_ok;
  logic              set_req;

  alarm_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .word_q   (alarm_word),
    .en_q     (alarm_en),
    .ie_q     (irq_en),
    .clr_req  (clr_req)
  );

  // live time packed in the same layout as the alarm word
  always_comb begin
    live_word        = '0;
    live_word[6:0]   = now_sec;
    live_word[14:8]  = now_min;
    live_word[21:16] = now_hour;
    live_word[22]    = now_pm;
    live_word[29:24] = now_date;
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    localparam int unsigned LSB = FLD_LSB[g];
    localparam int unsigned FW  = FLD_W[g];
    alarm_field_cmp #(.W(FW)) u_cmp (
      .want     (alarm_word[LSB +: FW]),
      .have     (live_word[LSB +: FW]),
      .dont_care(alarm_word[FLD_DC[g]]),
      .hit      (fld_hit[g])
    );
  end

  always_comb begin
    div_ok  = alarm_word[FLD_DC[0]] || (32'(sync_div) >= MIN_SEC_DIV);
    set_req = tick_1hz && alarm_en && (&fld_hit) && div_ok;
  end

  alarm_flag_reg u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(set_req),
    .clr_req(clr_req),
    .flag_q (alarm_flag)
  );

  always_comb alarm_irq = alarm_flag && irq_en;
endmodule

// File: rtl/bcd_alarm_chk.sv
module bcd_alarm_chk
  import bcd_alarm_pkg::*;
#(
  parameter int unsigned MIN_SEC_DIV = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              tick_1hz,
  input logic [DIV_W-1:0]  sync_div,
  input logic [WORD_W-1:0] alarm_word,
  input logic              alarm_en,
  input logic              alarm_flag,
  input logic              alarm_irq
);
  logic clr_wr;
  always_comb clr_wr = reg_wr && (reg_addr == A_CLR) && reg_wdata[CLR_BIT];

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick_1hz && alarm_en)); // R5
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alarm_flag); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !tick_1hz) |=> !alarm_flag); // R8
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !clr_wr) |=> $stable(alarm_flag)); // R6
  AST_DIV_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !alarm_word[FLD_DC[0]] && (32'(sync_div) < MIN_SEC_DIV) && !alarm_flag)
      |=> !alarm_flag); // R9
endmodule

bind bcd_alarm_match bcd_alarm_chk #(.MIN_SEC_DIV(MIN_SEC_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .tick_1hz  (tick_1hz),
  .sync_div  (sync_div),
  .alarm_word(alarm_word),
  .alarm_en  (alarm_en),
  .alarm_flag(alarm_flag),
  .alarm_irq (alarm_irq)
);

// File: tb/test_bcd_alarm_match.sv
module test_bcd_alarm_match;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        tick_1hz = 1'b0;
  logic [14:0] sync_div = 15'd255;
  logic [6:0]  now_sec = '0;
  logic [6:0]  now_min = '0;
  logic [5:0]  now_hour = '0;
  logic        now_pm = 1'b0;
  logic [5:0]  now_date = '0;
  logic        alarm_flag;
  logic        alarm_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_alarm_match i_bcd_alarm_match (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tick_1hz(tick_1hz), .sync_div(sync_div),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_pm(now_pm), .now_date(now_date),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  // alarm word built from decimal values and masks {date,hour,min,sec}
  function automatic logic [31:0] mk_word(input int s, input int m, input int h,
                                          input logic pm, input int d, input logic [3:0] msk);
    logic [31:0] w;
    w = '0;
    w[6:0] = bcd(s)[6:0]; w[14:8] = bcd(m)[6:0];
    w[21:16] = bcd(h)[5:0]; w[22] = pm; w[29:24] = bcd(d)[5:0];
    w[7] = msk[0]; w[15] = msk[1]; w[23] = msk[2]; w[31] = msk[3];
    return w;
  endfunction

  task automatic set_now(input int s, input int m, input int h, input logic pm, input int d);
    now_sec = bcd(s)[6:0]; now_min = bcd(m)[6:0];
    now_hour = bcd(h)[5:0]; now_pm = pm; now_date = bcd(d)[5:0];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state; enable cleared so a matching tick does nothing
    check("R1 flag", alarm_flag, 1'b0);
    check("R1 irq", alarm_irq, 1'b0);
    wr(2'd0, 32'h8080_8080);
    pulse_tick();
    check("R1 enable off after reset", alarm_flag, 1'b0);

    // R2 R3 R4 R7: masks x mismatch position sweep
    for (int msk = 0; msk < 16; msk++) begin
      for (int p = 0; p < 10; p++) begin
        int s, m, h, d, mis;
        logic pm, exp, ie;
        s = (msk * 7 + p * 11) % 60; m = (msk * 13 + p * 5) % 60;
        h = (msk + p * 3) % 12 + 1; d = (msk * 3 + p) % 31 + 1;
        pm = logic'(p % 2); mis = p % 5; ie = logic'((p / 5) % 2);
        wr(2'd0, mk_word(s, m, h, pm, d, 4'(msk)));
        wr(2'd1, (32'(ie) << 12) | 32'h100);
        wr(2'd2, 32'h1);
        case (mis)
          0: set_now((s + 1) % 60, m, h, pm, d);
          1: set_now(s, (m + 1) % 60, h, pm, d);
          2: if (p % 2 == 1) set_now(s, m, h, ~pm, d);  // PM-only difference
             else            set_now(s, m, h % 12 + 1, pm, d);
          3: set_now(s, m, h, pm, d % 31 + 1);
          default: set_now(s, m, h, pm, d);
        endcase
        exp = (mis == 4) || msk[mis];
        pulse_tick();
        check(mis == 2 ? "R4 hour/pm compare" : (mis == 4 ? "R2 full match" : "R3 mask"),
              alarm_flag, exp);
        check("R7 irq", alarm_irq, exp & ie);
      end
    end

    // R9: divider threshold sweep, second field masked and unmasked
    for (int dv = 0; dv < 6; dv++) begin
      for (int sm = 0; sm < 2; sm++) begin
        sync_div = 15'(dv);
        wr(2'd0, mk_word(30, 15, 10, 1'b0, 20, {3'b000, 1'(sm)}));
        wr(2'd1, 32'h100);
        wr(2'd2, 32'h1);
        set_now(30, 15, 10, 1'b0, 20);
        pulse_tick();
        check("R9 divider guard", alarm_flag, logic'(sm == 1 || dv >= 3));
      end
    end
    sync_div = 15'd255;

    // R5: matching time without tick
    wr(2'd0, mk_word(5, 6, 7, 1'b0, 8, 4'b0000));
    wr(2'd1, 32'h1100);
    wr(2'd2, 32'h1);
    set_now(5, 6, 7, 1'b0, 8);
    repeat (4) @(negedge clk);
    check("R5 no tick", alarm_flag, 1'b0);
    pulse_tick();
    check("R5 tick", alarm_flag, 1'b1);

    // R8: clear with bit0=0 ignored, bit0=1 clears
    wr(2'd2, 32'hFFFF_FFFE);
    check("R8 zero write ignored", alarm_flag, 1'b1);
    wr(2'd2, 32'h1);
    check("R8 clear", alarm_flag, 1'b0);
    check("R8 irq follows", alarm_irq, 1'b0);

    // R6: disable suppresses, held flag stays
    pulse_tick();
    check("R6 enabled set", alarm_flag, 1'b1);
    wr(2'd1, 32'h0);
    check("R6 flag kept after disable", alarm_flag, 1'b1);
    check("R7 irq off with ie=0", alarm_irq, 1'b0);
    wr(2'd2, 32'h1);
    pulse_tick();
    check("R6 disabled no set", alarm_flag, 1'b0);

    // R8: set and clear in the same cycle, set wins
    wr(2'd1, 32'h100);
    @(negedge clk);
    tick_1hz = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h1;
    @(negedge clk);
    tick_1hz = 1'b0; reg_wr = 1'b0;
    check("R8 set beats clear", alarm_flag, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule